// File: doc/BRIEF.md
# Dual Timer/Counter with Four Counting Modes

This block holds two independent timer/counters, each built from an 8-bit high half and an 8-bit low half. A single mode register sets, per timer, a two-bit counting mode, a source select (internal clock enable or falling edges on an external count pin) and a gating bit that makes counting depend on an external gate pin. A control register holds one run bit and one overflow flag per timer.

The four modes are a 13-bit count with a 5-bit prescaler, a plain 16-bit count, an 8-bit count that reloads from the high half, and a split mode. In split mode timer 0 becomes two 8-bit counters. The second one takes over timer 1's run bit and overflow flag, while timer 1 keeps running and still feeds the baud pulse. Overflow flags serve as interrupt requests. They are cleared by a per-timer acknowledge input or by a control register write.

Top module: `dual_timer`

## Requirements
- R1: After reset every register reads 0, both flags are 0 and `baud_tick` is 0. Read and write selects are: 0 mode, 1 control, 2 timer 0 low, 3 timer 0 high, 4 timer 1 low, 5 timer 1 high.
- R2: Mode 0 is a 13-bit count. Only the low 5 bits of the low half count. The high half advances when those 5 bits wrap from 31. The upper 3 bits of the low half keep their written value. When all 13 bits wrap, the timer's flag is set.
- R3: Mode 1 is a 16-bit count. The flag is set when the count wraps from 0xFFFF to 0.
- R4: Mode 2 counts the low half only. When it would wrap from 0xFF, it loads the high half instead and sets the flag.
- R5: When timer 0 is in mode 3, its low half is an 8-bit counter under timer 0's controls and sets flag 0. Its high half counts the internal clock enable whenever run bit 1 is set, and sets flag 1 on wrap.
- R6: Timer 1 in mode 3 holds its count. While timer 0 is in mode 3, timer 1 counts regardless of run bit 1, and its overflows leave flag 1 untouched.
- R7: With gate bit 0, a timer counts only while its run bit is set. With gate bit 1, it also needs its gate pin high. Mode register fields per timer: [1:0] mode, [2] source select, [3] gate. Timer 0 uses bits 3..0 and timer 1 uses bits 7..4.
- R8: With source select 1, the timer counts each falling edge of its synchronized count pin and ignores the clock enable.
- R9: Control register: bit 0 is run 0, bit 1 is flag 0, bit 2 is run 1, bit 3 is flag 1. A write there loads all four bits. An acknowledge input clears its flag. A hardware overflow in the same cycle leaves the flag set.
- R10: `baud_tick` is high for exactly the one cycle that follows each timer 1 overflow.
- R11: A write to a count register in a cycle in which that count would also advance loads the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Internal count enable |
| cnt_pin | input | 2 | External count pins, one per timer |
| gate_pin | input | 2 | External gate pins, one per timer |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register write select |
| wr_data | input | 8 | Register write data |
| rd_sel | input | 3 | Register read select |
| rd_data | output | 8 | Register read data |
| int_ack | input | 2 | Per-timer interrupt acknowledge |
| ovf_flag | output | 2 | Per-timer overflow flags (interrupt requests) |
| baud_tick | output | 1 | Timer 1 overflow pulse |

## Verification
The bench builds the block with `SYNC_STAGES` set to 3, one stage above the default. This makes pin-driven counting and gating go through a longer synchronizer. Event counts are checked after every level has settled, so they must come out the same whatever the chain length. Tick counts are chosen to land exactly on the wrap points of each mode. This covers the prescaler carry, the 16-bit wrap, the reload, and flag 1 changing owner when timer 0 is in mode 3.

// File: rtl/dual_timer.sv
module dual_timer #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic [1:0] cnt_pin,
  input  logic [1:0] gate_pin,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_sel,
  output logic [7:0] rd_data,
  input  logic [1:0] int_ack,
  output logic [1:0] ovf_flag,
  output logic       baud_tick
);
  localparam int SMSB = SYNC_STAGES - 1;
  localparam logic [2:0] SEL_MODE = 3'd0, SEL_CTRL = 3'd1, SEL_T0L = 3'd2,
                         SEL_T0H = 3'd3, SEL_T1L = 3'd4, SEL_T1H = 3'd5;

  logic [7:0] mode_q, t0l, t0h, t1l, t1h;
  logic [1:0] run_q, flag_q, flag_nx;
  logic       baud_q;
  logic [1:0][SMSB:0] csy, gsy;
  logic [1:0] cprev, cnow, gnow, fall;

  // returns {overflow, next high, next low}
  function automatic logic [16:0] advance(input logic [1:0] m, input logic [7:0] lo,
                                          input logic [7:0] hi, input logic go);
    logic [7:0] nl, nh;
    logic ov;
    nl = lo; nh = hi; ov = 1'b0;
    if (go) begin
      case (m)
        2'd0: begin
          nl[4:0] = lo[4:0] + 5'd1;
          if (&lo[4:0]) begin
            nh = hi + 8'd1;
            ov = &hi;
          end
        end
        2'd1: begin
          {nh, nl} = {hi, lo} + 16'd1;
          ov = &{hi, lo};
        end
        2'd2: begin
          nl = (&lo) ? hi : lo + 8'd1;
          ov = &lo;
        end
        default: begin
          nl = lo + 8'd1;
          ov = &lo;
        end
      endcase
    end
    return {ov, nh, nl};
  endfunction

  assign cnow = {csy[1][SMSB], csy[0][SMSB]};
  assign gnow = {gsy[1][SMSB], gsy[0][SMSB]};
  assign fall = cprev & ~cnow;

  logic split, t1_halt, en0, en1, src0, src1, hgo, hev, ev0, ev1, t1_ev;
  logic [7:0] n0l, n0h_m, n0h, n1l, n1h;

  assign split   = mode_q[1:0] == 2'd3;
  assign t1_halt = mode_q[5:4] == 2'd3;
  assign src0 = mode_q[2] ? fall[0] : tick_en;
  assign src1 = mode_q[6] ? fall[1] : tick_en;
  assign en0  = run_q[0] & (~mode_q[3] | gnow[0]);
  assign en1  = (run_q[1] | split) & (~mode_q[7] | gnow[1]);

  assign {ev0, n0h_m, n0l} = advance(mode_q[1:0], t0l, t0h, en0 & src0);
  assign {t1_ev, n1h, n1l} = advance(mode_q[5:4], t1l, t1h, en1 & src1 & ~t1_halt);

  assign hgo = split & run_q[1] & tick_en;
  assign hev = hgo & (&t0h);
  assign n0h = hgo ? t0h + 8'd1 : n0h_m;
  assign ev1 = split ? hev : t1_ev;

  logic wr_ctrl;
  assign wr_ctrl = wr_en && wr_sel == SEL_CTRL;

  always_comb begin
    flag_nx = flag_q & ~int_ack;
    if (wr_ctrl) flag_nx = {wr_data[3], wr_data[1]};
    flag_nx = flag_nx | {ev1, ev0};   // R9: hardware set has the last word
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0; run_q <= '0; flag_q <= '0; baud_q <= 1'b0;
      t0l <= '0; t0h <= '0; t1l <= '0; t1h <= '0;
      csy <= '0; gsy <= '0; cprev <= '0;
    end else begin
      for (int k = 0; k < 2; k++) begin
        csy[k] <= {csy[k][SMSB-1:0], cnt_pin[k]};
        gsy[k] <= {gsy[k][SMSB-1:0], gate_pin[k]};
      end
      cprev  <= cnow;
      mode_q <= (wr_en && wr_sel == SEL_MODE) ? wr_data : mode_q;
      if (wr_ctrl) run_q <= {wr_data[2], wr_data[0]};
      flag_q <= flag_nx;
      baud_q <= t1_ev;
      t0l <= (wr_en && wr_sel == SEL_T0L) ? wr_data : n0l;
      t0h <= (wr_en && wr_sel == SEL_T0H) ? wr_data : n0h;
      t1l <= (wr_en && wr_sel == SEL_T1L) ? wr_data : n1l;
      t1h <= (wr_en && wr_sel == SEL_T1H) ? wr_data : n1h;
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_MODE: rd_data = mode_q;
      SEL_CTRL: rd_data = {4'd0, flag_q[1], run_q[1], flag_q[0], run_q[0]};
      SEL_T0L:  rd_data = t0l;
      SEL_T0H:  rd_data = t0h;
      SEL_T1L:  rd_data = t1l;
      SEL_T1H:  rd_data = t1h;
      default:  rd_data = 8'd0;
    endcase
  end

  assign ovf_flag  = flag_q;
  assign baud_tick = baud_q;
endmodule

// File: rtl/dual_timer_chk.sv
module dual_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_sel,
  input logic [1:0] int_ack,
  input logic [1:0] ovf_flag,
  input logic       baud_tick,
  input logic       ev0,
  input logic       split,
  input logic       t1_halt,
  input logic       run0,
  input logic [7:0] t0_lo,
  input logic [7:0] t1_lo,
  input logic [7:0] t1_hi
);
  AST_FLAG0_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev0 |=> ovf_flag[0]);  // R9

  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack[0] && !ev0 && !(wr_en && wr_sel == 3'd1) |=> !ovf_flag[0]);  // R9

  AST_T1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    t1_halt && !(wr_en && (wr_sel == 3'd4 || wr_sel == 3'd5)) |=> $stable({t1_hi, t1_lo}));  // R6

  AST_T0_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run0 && !(wr_en && wr_sel == 3'd2) |=> $stable(t0_lo));  // R7

  AST_BAUD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick && !$past(split) |-> ovf_flag[1]);  // R10
endmodule

bind dual_timer dual_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .int_ack(int_ack),
  .ovf_flag(ovf_flag), .baud_tick(baud_tick), .ev0(ev0), .split(split),
  .t1_halt(t1_halt), .run0(run_q[0]), .t0_lo(t0l), .t1_lo(t1l), .t1_hi(t1h)
);

// File: tb/sim_dual_timer.sv
module sim_dual_timer;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, tick_en, wr_en;
  logic [1:0] cnt_pin, gate_pin, int_ack, ovf_flag;
  logic [2:0] wr_sel, rd_sel;
  logic [7:0] wr_data, rd_data;
  logic baud_tick;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  dual_timer #(.SYNC_STAGES(3)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .int_ack(int_ack), .ovf_flag(ovf_flag), .baud_tick(baud_tick));

  localparam logic [2:0] MODE = 0, CTRL = 1, T0L = 2, T0H = 3, T1L = 4, T1H = 5;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic peek(input string req, input logic [2:0] s, input int exp);
    rd_sel = s; #1;
    check(req, $sformatf("reg %0d", s), rd_data, exp);
  endtask

  task automatic tick(input int n);
    @(negedge clk); tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic t_reset;
    for (int s = 0; s < 6; s++) peek("R1", 3'(s), 0);
    check("R1", "flags", ovf_flag, 0);
    check("R1", "baud", baud_tick, 0);
  endtask

  task automatic t_mode1;
    wr(MODE, 8'h01); wr(T0L, 8'hFE); wr(T0H, 8'hFF); wr(CTRL, 8'h01);
    tick(1);
    peek("R3", T0L, 8'hFF); check("R3", "flag0 early", ovf_flag[0], 0);
    tick(1);
    peek("R3", T0L, 8'h00); peek("R3", T0H, 8'h00);
    check("R3", "flag0 on wrap", ovf_flag[0], 1);
    wr(CTRL, 8'h00);
    check("R9", "write clears flag0", ovf_flag[0], 0);
  endtask

  task automatic t_mode0;
    wr(MODE, 8'h00); wr(T0L, 8'hFE); wr(T0H, 8'hFF); wr(CTRL, 8'h01);
    tick(1);
    peek("R2", T0L, 8'hFF); check("R2", "no flag yet", ovf_flag[0], 0);
    tick(1);
    peek("R2", T0L, 8'hE0); peek("R2", T0H, 8'h00);
    check("R2", "13-bit wrap flag", ovf_flag[0], 1);
    wr(CTRL, 8'h01); wr(T0L, 8'h1F); wr(T0H, 8'h10);
    tick(1);
    peek("R2", T0L, 8'h00); peek("R2", T0H, 8'h11);
    check("R2", "carry no flag", ovf_flag[0], 0);
  endtask

  task automatic t_mode2;
    wr(MODE, 8'h02); wr(T0H, 8'hF0); wr(T0L, 8'hFE); wr(CTRL, 8'h01);
    tick(2);
    peek("R4", T0L, 8'hF0); check("R4", "reload flag", ovf_flag[0], 1);
    tick(1);
    peek("R4", T0L, 8'hF1);
    @(negedge clk); int_ack = 2'b01;
    @(negedge clk); int_ack = 2'b00;
    check("R9", "ack clears flag0", ovf_flag[0], 0);
    wr(CTRL, 8'h02);
    peek("R9", CTRL, 8'h02);
  endtask

  task automatic t_flag_priority;
    wr(MODE, 8'h01); wr(T0L, 8'hFF); wr(T0H, 8'hFF); wr(CTRL, 8'h01);
    @(negedge clk); tick_en = 1'b1; int_ack = 2'b01;
    @(negedge clk); tick_en = 1'b0; int_ack = 2'b00;
    check("R9", "set beats ack", ovf_flag[0], 1);
    wr(T0L, 8'h00); wr(T0H, 8'h00);
    @(negedge clk); tick_en = 1'b1; wr_en = 1'b1; wr_sel = T0L; wr_data = 8'h40;
    @(negedge clk); tick_en = 1'b0; wr_en = 1'b0;
    peek("R11", T0L, 8'h40);
  endtask

  task automatic t_split;
    wr(MODE, 8'h13); wr(T0L, 8'hFF); wr(T0H, 8'hFF); wr(T1L, 8'h00); wr(T1H, 8'h00);
    wr(CTRL, 8'h01);
    tick(1);
    peek("R5", T0L, 8'h00); peek("R5", T0H, 8'hFF);
    check("R5", "flag0 from low half", ovf_flag, 2'b01);
    peek("R6", T1L, 8'h01);
    wr(CTRL, 8'h04);
    tick(1);
    peek("R5", T0H, 8'h00); peek("R5", T0L, 8'h00);
    check("R5", "flag1 from high half", ovf_flag, 2'b10);
    peek("R6", T1L, 8'h02);
    wr(T1L, 8'hFF); wr(T1H, 8'hFF); wr(CTRL, 8'h00);
    tick(1);
    check("R10", "baud under split", baud_tick, 1);
    check("R6", "flag1 untouched", ovf_flag[1], 0);
    peek("R6", T1L, 8'h00);
    @(negedge clk);
    check("R10", "baud one cycle", baud_tick, 0);
  endtask

  task automatic t_t1_stop;
    wr(MODE, 8'h30); wr(T1L, 8'h05); wr(T1H, 8'h00); wr(CTRL, 8'h04);
    tick(3);
    peek("R6", T1L, 8'h05);
    check("R6", "no baud", baud_tick, 0);
  endtask

  task automatic t_gate;
    wr(MODE, 8'h09); wr(T0L, 8'h00); wr(T0H, 8'h00); wr(CTRL, 8'h01);
    gate_pin[0] = 1'b0; repeat (6) @(negedge clk);
    tick(4);
    peek("R7", T0L, 8'h00);
    gate_pin[0] = 1'b1; repeat (6) @(negedge clk);
    tick(4);
    peek("R7", T0L, 8'h04);
    wr(CTRL, 8'h00);
    tick(4);
    peek("R7", T0L, 8'h04);
  endtask

  task automatic t_pin;
    wr(MODE, 8'h05); wr(T0L, 8'h00); wr(T0H, 8'h00); wr(CTRL, 8'h01);
    for (int k = 0; k < 3; k++) begin
      cnt_pin[0] = 1'b1; repeat (6) @(negedge clk);
      cnt_pin[0] = 1'b0; repeat (6) @(negedge clk);
    end
    peek("R8", T0L, 8'h03);
    tick(5);
    peek("R8", T0L, 8'h03);
  endtask

  task automatic t_baud;
    wr(MODE, 8'h20); wr(T1H, 8'hFE); wr(T1L, 8'hFE); wr(CTRL, 8'h04);
    tick(1);
    peek("R4", T1L, 8'hFF); check("R10", "no baud early", baud_tick, 0);
    tick(1);
    peek("R4", T1L, 8'hFE); peek("R9", CTRL, 8'h0C);
    check("R10", "baud on overflow", baud_tick, 1);
    @(negedge clk);
    check("R10", "baud drops", baud_tick, 0);
  endtask

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    rd_sel = '0; cnt_pin = '0; gate_pin = '0; int_ack = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset; t_mode1; t_mode0; t_mode2; t_flag_priority;
    t_split; t_t1_stop; t_gate; t_pin; t_baud;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule